// File: doc/BRIEF.md
# PHY and Root Reset Link-Up Sequencer

This block brings a serial link controller from reset to a trained link with no software in the loop. A one-cycle start pulse makes it raise two reset-release requests together: one for the PHY and one for the root logic. It then watches a three-bit readiness input until the PLL, the PHY and the root logic all report ready. After that it waits a fixed settling time and watches a packed link status word until the lane-width field turns non-zero.

A free-running millisecond tick paces every wait. Each of the two watch phases has a retry limit counted in ticks. When the link comes up, the sequencer raises `done` and keeps the lane width and generation. If readiness never arrives, it raises a reset-timeout flag instead. If the link never trains, it raises a link-fail flag instead. The outcome stays on the outputs until the next start pulse. A synchronous reset returns the block to idle.

Top module: `link_up_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle: `rst_req` is 2'b00, and `done`, `rst_timeout`, `link_fail`, `link_width` and `link_gen` are all zero.
- R2: A start pulse accepted in idle, done or fail sets `rst_req` to 2'b11 at the next edge and clears all three outcome flags and both captured fields. Bit 0 of `rst_req` is the PHY request and bit 1 is the root request. The requests stay high until `rst`.
- R3: A start pulse that arrives while a sequence is still in progress has no effect. Outcome and tick timing stay as if it had not come.
- R4: `rst_status` is sampled only on tick cycles. Bit 0 is PLL lock, bit 1 is PHY ready and bit 2 is root ready. The reset phase ends only on a tick where the value is 3'b111; any two of the three bits are not enough.
- R5: The reset phase samples at most `RST_POLL_MAX` ticks (200). If the 200th sample is not 3'b111, `rst_timeout` rises right after that tick and `done` stays low. If the 200th sample is 3'b111, the sequence goes on.
- R6: After the tick that completes the reset phase, `SETTLE_TICKS` ticks (20) pass with `link_status` ignored. The first link sample is the 21st tick after readiness.
- R7: On a link sample where bits 7:0 of `link_status` are non-zero, `done` rises right after that tick. `link_width` takes bits 7:0 and `link_gen` takes bits 11:8. Bits above 11 are ignored.
- R8: The link phase samples at most `LINK_POLL_MAX` ticks (20). If bits 7:0 are still zero on the 20th sample, `link_fail` rises and `done` stays low. A non-zero width on the 20th sample still gives `done`.
- R9: In the done and fail states, the outcome flags and the captured fields hold. Further ticks and status changes do not alter them, until the next start.
- R10: State advances only on `ms_tick` cycles. An outcome therefore rises only on the edge that consumes a tick.
- R11: At most one of `done`, `rst_timeout` and `link_fail` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a sequence |
| ms_tick | input | 1 | One-cycle millisecond pacing pulse |
| rst_status | input | 3 | Readiness: bit 0 PLL lock, bit 1 PHY ready, bit 2 root ready |
| link_status | input | LINK_W | Link word: bits 7:0 lane width, bits 11:8 generation |
| rst_req | output | 2 | Reset-release requests: bit 0 PHY, bit 1 root |
| done | output | 1 | Link trained, fields valid |
| rst_timeout | output | 1 | Readiness not reached within the poll limit |
| link_fail | output | 1 | Lane width still zero after the last link sample |
| link_width | output | 8 | Captured lane width |
| link_gen | output | 4 | Captured link generation |

## Verification
The assertions assume that `start` and `ms_tick` are single-cycle pulses. They also assume that the status inputs hold steady through the edge that consumes a tick, so `$past` of an input taken on that edge is the value the sequencer saw. The stimulus changes inputs only at falling edges. It keeps each tick high for exactly one cycle, with two idle cycles between ticks. It raises `start` on a cycle without a tick, and only once during a run, to show that the pulse is ignored. The readiness and link words follow the bench's own tick count, so each outcome tick is known before the run starts.

// File: rtl/lus_pkg.sv
package lus_pkg;

    localparam int WID_W   = 8;
    localparam int GEN_W   = 4;
    localparam int GEN_LSB = 8;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_RST_WAIT  = 3'd1,
        S_SETTLE    = 3'd2,
        S_LINK_POLL = 3'd3,
        S_DONE      = 3'd4,
        S_FAIL      = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic [1:0]       req;
        logic             done;
        logic             rto;
        logic             lfail;
        logic [WID_W-1:0] width;
        logic [GEN_W-1:0] gen;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state: S_IDLE, req: 2'b00, done: 1'b0, rto: 1'b0, lfail: 1'b0,
        width: '0, gen: '0
    };

endpackage

// File: rtl/lus_tick_timer.sv
module lus_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // current tick is the final permitted one in this phase
    assign last = (cnt_q == (limit - CNT_W'(1)));
endmodule

// File: rtl/lus_ready_decode.sv
module lus_ready_decode #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] ready_bits,
    output logic               all_ready
);
    assign all_ready = &ready_bits;
endmodule

// File: rtl/lus_link_decode.sv
module lus_link_decode
    import lus_pkg::*;
#(
    parameter int LINK_W = 16
) (
    input  logic [LINK_W-1:0] link_word,
    output logic              link_up,
    output logic [WID_W-1:0]  width,
    output logic [GEN_W-1:0]  gen
);
    localparam int USED_W = GEN_LSB + GEN_W;

    assign width   = link_word[WID_W-1:0];
    assign gen     = link_word[GEN_LSB +: GEN_W];
    assign link_up = |width;

    generate
        if (LINK_W > USED_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^link_word[LINK_W-1:USED_W];
        end
    endgenerate
endmodule

// File: rtl/link_up_seq.sv
module link_up_seq
    import lus_pkg::*;
#(
    parameter int RST_POLL_MAX  = 200,
    parameter int SETTLE_TICKS  = 20,
    parameter int LINK_POLL_MAX = 20,
    parameter int LINK_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ms_tick,
    input  logic [2:0]        rst_status,
    input  logic [LINK_W-1:0] link_status,
    output logic [1:0]        rst_req,
    output logic              done,
    output logic              rst_timeout,
    output logic              link_fail,
    output logic [WID_W-1:0]  link_width,
    output logic [GEN_W-1:0]  link_gen
);
    localparam int MAX_AB  = (RST_POLL_MAX > SETTLE_TICKS) ? RST_POLL_MAX : SETTLE_TICKS;
    localparam int CNT_MAX = (MAX_AB > LINK_POLL_MAX) ? MAX_AB : LINK_POLL_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_regs_t        d, q;
    logic             all_ready, link_up;
    logic [WID_W-1:0] dec_width;
    logic [GEN_W-1:0] dec_gen;
    logic             tmr_clr, tmr_step, tmr_last;
    logic [CNT_W-1:0] tmr_limit;

    lus_ready_decode #(.NUM_SRC(3)) u_ready (
        .ready_bits (rst_status),
        .all_ready  (all_ready)
    );

    lus_link_decode #(.LINK_W(LINK_W)) u_link (
        .link_word (link_status),
        .link_up   (link_up),
        .width     (dec_width),
        .gen       (dec_gen)
    );

    lus_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .step  (tmr_step),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    always_comb begin
        unique case (q.state)
            S_RST_WAIT: tmr_limit = CNT_W'(RST_POLL_MAX);
            S_SETTLE:   tmr_limit = CNT_W'(SETTLE_TICKS);
            default:    tmr_limit = CNT_W'(LINK_POLL_MAX);
        endcase
    end

    always_comb begin
        d        = q;
        tmr_clr  = 1'b0;
        tmr_step = 1'b0;
        unique case (q.state)
            S_IDLE, S_DONE, S_FAIL: begin
                tmr_clr = 1'b1;
                if (start) begin
                    d.state = S_RST_WAIT;
                    d.req   = 2'b11;
                    d.done  = 1'b0;
                    d.rto   = 1'b0;
                    d.lfail = 1'b0;
                    d.width = '0;
                    d.gen   = '0;
                end
            end
            S_RST_WAIT: begin
                if (ms_tick) begin
                    if (all_ready) begin
                        d.state = S_SETTLE;
                        tmr_clr = 1'b1;
                    end else if (tmr_last) begin
                        d.state = S_FAIL;
                        d.rto   = 1'b1;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_step = 1'b1;
                    end
                end
            end
            S_SETTLE: begin
                if (ms_tick) begin
                    if (tmr_last) begin
                        d.state = S_LINK_POLL;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_step = 1'b1;
                    end
                end
            end
            S_LINK_POLL: begin
                if (ms_tick) begin
                    if (link_up) begin
                        d.state = S_DONE;
                        d.done  = 1'b1;
                        d.width = dec_width;
                        d.gen   = dec_gen;
                        tmr_clr = 1'b1;
                    end else if (tmr_last) begin
                        d.state = S_FAIL;
                        d.lfail = 1'b1;
                        tmr_clr = 1'b1;
                    end else begin
                        tmr_step = 1'b1;
                    end
                end
            end
            default: begin
                d       = SEQ_RESET;
                tmr_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEQ_RESET;
        end else begin
            q <= d;
        end
    end

    assign rst_req     = q.req;
    assign done        = q.done;
    assign rst_timeout = q.rto;
    assign link_fail   = q.lfail;
    assign link_width  = q.width;
    assign link_gen    = q.gen;
endmodule

// File: rtl/lus_checker.sv
module lus_checker #(
    parameter int LINK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              ms_tick,
    input logic [2:0]        rst_status,
    input logic [LINK_W-1:0] link_status,
    input logic [1:0]        rst_req,
    input logic              done,
    input logic              rst_timeout,
    input logic              link_fail,
    input logic [7:0]        link_width,
    input logic [3:0]        link_gen
);
    generate
        if (LINK_W > 12) begin : g_spare
            logic unused_chk;
            assign unused_chk = ^link_status[LINK_W-1:12];
        end
    endgenerate

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({done, rst_timeout, link_fail}) <= 1);

    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        (done || rst_timeout || link_fail) |-> (rst_req == 2'b11));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(link_width) && $stable(link_gen)));

    assert_lfail_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (link_fail && !start) |=> link_fail);

    assert_rto_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rst_timeout && !start) |=> rst_timeout);

    assert_done_width_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (link_width != 8'd0));

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (link_width == $past(link_status[7:0]) &&
                         link_gen == $past(link_status[11:8])));

    assert_done_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ms_tick));

    assert_rto_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_timeout) |-> ($past(ms_tick) && $past(rst_status) != 3'b111));

    assert_lfail_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(link_fail) |-> ($past(ms_tick) && $past(link_status[7:0]) == 8'd0));
endmodule

bind link_up_seq lus_checker #(.LINK_W(LINK_W)) u_lus_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .ms_tick     (ms_tick),
    .rst_status  (rst_status),
    .link_status (link_status),
    .rst_req     (rst_req),
    .done        (done),
    .rst_timeout (rst_timeout),
    .link_fail   (link_fail),
    .link_width  (link_width),
    .link_gen    (link_gen)
);

// File: tb/tb_link_up_seq.sv
`timescale 1ns/1ps
module tb_link_up_seq;
    localparam int RPOLL  = 200;
    localparam int SETTLE = 20;
    localparam int LPOLL  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ms_tick = 1'b0;
    logic [2:0]  rst_status = 3'b000;
    logic [15:0] link_status = 16'h0000;
    logic [1:0]  rst_req;
    logic        done, rst_timeout, link_fail;
    logic [7:0]  link_width;
    logic [3:0]  link_gen;

    int checks = 0;
    int errors = 0;
    int tick_idx = 0;
    bit seen = 1'b0;
    bit prev_out = 1'b0;
    int cycles = 0;

    typedef struct {
        int kind;   // 0 done, 1 reset timeout, 2 link fail
        int tick;
        int width;
        int gen;
        string req;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    link_up_seq dut (
        .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
        .rst_status(rst_status), .link_status(link_status),
        .rst_req(rst_req), .done(done), .rst_timeout(rst_timeout),
        .link_fail(link_fail), .link_width(link_width), .link_gen(link_gen)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops an expected outcome when one appears
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if ((done || rst_timeout || link_fail) && !prev_out && !rst) begin
                int kind;
                kind = done ? 0 : (rst_timeout ? 1 : 2);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected outcome", kind, -1);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(kind == e.kind, e.req, "outcome kind", kind, e.kind);
                    chk(tick_idx == e.tick, e.req, "outcome tick", tick_idx, e.tick);
                    chk(int'(link_width) == e.width, e.req, "width", link_width, e.width);
                    chk(int'(link_gen) == e.gen, e.req, "gen", link_gen, e.gen);
                end
                seen = 1'b1;
            end
            prev_out = done || rst_timeout || link_fail;
        end
    end

    task automatic drive_status(input int ready_at, input logic [2:0] pre,
                                input int link_abs, input logic [15:0] word);
        rst_status  = (tick_idx >= ready_at) ? 3'b111 : pre;
        link_status = (tick_idx >= link_abs) ? word : (word & 16'hFF00);
    endtask

    task automatic run_case(input string req, input int ready_at, input logic [2:0] pre,
                            input int link_abs, input logic [15:0] word, input int restart_at);
        exp_t e;
        int first_poll, last_poll, up;
        e.req = req;
        e.width = 0;
        e.gen = 0;
        if (ready_at > RPOLL) begin
            e.kind = 1; e.tick = RPOLL;
        end else begin
            first_poll = ready_at + SETTLE + 1;
            last_poll  = ready_at + SETTLE + LPOLL;
            up = (link_abs > first_poll) ? link_abs : first_poll;
            if (up <= last_poll && word[7:0] != 8'd0) begin
                e.kind = 0; e.tick = up; e.width = word[7:0]; e.gen = word[11:8];
            end else begin
                e.kind = 2; e.tick = last_poll;
            end
        end
        sbq.push_back(e);
        seen = 1'b0;
        tick_idx = 0;
        @(negedge clk);
        drive_status(ready_at, pre, link_abs, word);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: requests raised, earlier outcome cleared
        chk(rst_req == 2'b11, "R2", "rst_req after start", rst_req, 3);
        chk({done, rst_timeout, link_fail, link_width, link_gen} == '0, "R2",
            "outcome cleared after start", {done, rst_timeout, link_fail}, 0);
        while (!seen && tick_idx < 260) begin
            @(negedge clk);
            tick_idx++;
            drive_status(ready_at, pre, link_abs, word);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            if (tick_idx == restart_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        chk(seen, req, "outcome reached", seen, 1);
    endtask

    // R9: outcome holds while ticks run and inputs change
    task automatic hold_check();
        logic [14:0] snap;
        snap = {done, rst_timeout, link_fail, link_width, link_gen};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rst_status  = 3'b000;
            link_status = 16'hABCD;
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
        chk({done, rst_timeout, link_fail, link_width, link_gen} == snap, "R9",
            "outcome held", {done, rst_timeout, link_fail, link_width, link_gen}, snap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(rst_req == 2'b00, "R1", "rst_req after reset", rst_req, 0);
        chk({done, rst_timeout, link_fail, link_width, link_gen} == '0, "R1",
            "outputs after reset", {done, rst_timeout, link_fail}, 0);

        // R4 R7: two-of-three ready before tick 5, upper nibble junk ignored
        run_case("R7", 5, 3'b011, 30, 16'hF304, -1);
        hold_check();
        // R6: link already up during settling, first sample at tick 22
        run_case("R6", 1, 3'b000, 0, 16'h0210, -1);
        hold_check();
        // R5: readiness never complete
        run_case("R5", 1000, 3'b110, 0, 16'h0101, -1);
        hold_check();
        // R4 R5 R8: ready on the last reset sample, link never trains
        run_case("R8", RPOLL, 3'b101, 1000, 16'h0104, -1);
        hold_check();
        // R3: start pulse mid-sequence ignored
        run_case("R3", 9, 3'b100, 35, 16'h0402, 12);
        hold_check();
        // R8 R10: link up on the last allowed sample
        run_case("R8", 7, 3'b001, 7 + SETTLE + LPOLL, 16'h0108, -1);

        // R1: synchronous reset in mid-run clears everything
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rst_req == 2'b00, "R1", "rst_req after mid reset", rst_req, 0);
        chk({done, rst_timeout, link_fail, link_width, link_gen} == '0, "R1",
            "outputs after mid reset", link_width, 0);
        chk(sbq.size() == 0, "R11", "scoreboard drained", sbq.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule